// File: doc/BRIEF.md
# Transmit Self-Test Character Source

This block sits in front of the serializer of a transmit channel that carries 10-bit characters. In normal use it registers the parallel user character once per character slot. When a single-bit self-test enable is written through a small configuration write port, the same 10-bit data register becomes a pseudo-random character source. The source is a 9-bit maximal-length LFSR that repeats every 511 characters. A receiver that runs an identical LFSR can lock to the stream and check it character by character.

The enable is held in a latch that the active-low device reset clears, so the channel always comes out of reset sending user data. While self-test runs, the user input has no effect. A status output pulses on the character where the sequence restarts from its seed, which marks the period. Characters advance only on cycles where the character clock enable is high. The reset input is asynchronous and is released synchronously inside the block.

Top module: `txst_pattern_gen`

## Requirements
- R1: While reset is asserted, and until the first character after reset, `tx_char` is 0 and `seq_start` is 0. The enable latch is cleared, so characters taken after reset carry user data.
- R2: With self-test off, a cycle with `chr_ce` high loads `usr_data` into the data register, and it appears on `tx_char` after that clock edge.
- R3: A cycle with `cfg_wr` high loads `cfg_st_en` into the enable latch at that clock edge, independent of `chr_ce`.
- R4: The first character taken after the latch becomes 1 is the seed character 10'h001: LFSR state 9'h001, with bit 9 equal to state bit 8 XOR state bit 4, which is 0. `seq_start` is 1 on that character.
- R5: Each later character while self-test stays on carries state bits [8:0] = {previous state[7:0], previous state[8] XOR previous state[4]}, which is polynomial x^9 + x^5 + 1. Bit 9 of every self-test character equals its own bit 8 XOR bit 4.
- R6: The sequence has period 511. `seq_start` is 0 for the 510 characters that follow the seed and is 1 again on the 511th. No self-test character has state 0.
- R7: While self-test is active, the value on `usr_data` has no effect on `tx_char`.
- R8: When `chr_ce` is low, `tx_char` holds its value, in both modes.
- R9: After a write of 0 to the latch, the next character taken carries user data. A later write of 1 restarts the sequence from the seed character.
- R10: Asserting `rst_n` during self-test clears `tx_char` at once and clears the latch, so after release the channel carries user data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_wr | input | 1 | Configuration write strobe for the self-test enable latch |
| cfg_st_en | input | 1 | Value written to the enable latch |
| chr_ce | input | 1 | Character clock enable; the data register advances on cycles where it is high |
| usr_data | input | 10 | Parallel user character |
| tx_char | output | 10 | Registered character sent to the serializer |
| seq_start | output | 1 | High while the output is the seed character in self-test mode |

## Verification
The hardest behaviour to reach from the ports is the full-period property. The seed has to come back after exactly 511 characters and at no point in between. Proving this means driving one unbroken self-test run of more than 511 character slots and comparing every character against an LFSR model in the bench. During that run `usr_data` is set to a changing value on every slot, which also shows that user input is ignored throughout. A second hard case is the hand-over between modes. For this the bench places the latch writes in slots where `chr_ce` is low, then checks that the very next character is user data, or the seed again after re-enabling.

// File: rtl/txst_pkg.sv
package txst_pkg;
  // Default channel geometry
  localparam int unsigned TXST_CHAR_W   = 10;
  localparam int unsigned TXST_TAP      = 5;
  localparam int unsigned TXST_SYNC_LEN = 2;
endpackage

// File: rtl/txst_rst_sync.sv
module txst_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/txst_cfg_latch.sv
module txst_cfg_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_val,
  output logic en_o
);
  logic en_q;
  logic en_d;

  always_comb begin
    en_d = en_q;
    if (wr_en) en_d = wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_d;
  end

  assign en_o = en_q;
endmodule

// File: rtl/txst_lfsr_core.sv
module txst_lfsr_core #(
  parameter int unsigned CHAR_W = 10,
  parameter int unsigned TAP    = 5,
  parameter logic [CHAR_W-2:0] SEED = 'd1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              st_en,
  input  logic [CHAR_W-1:0] usr_data,
  output logic [CHAR_W-1:0] char_o,
  output logic              act_o,
  output logic              at_seed_o
);
  localparam int unsigned LFSR_W = CHAR_W - 1;

  logic [CHAR_W-1:0] dreg_q, dreg_d;
  logic              act_q, act_d;
  logic [LFSR_W-1:0] state, nxt_state;
  logic              fb_cur, fb_nxt, fb_seed;

  always_comb begin
    state     = dreg_q[LFSR_W-1:0];
    fb_cur    = state[LFSR_W-1] ^ state[TAP-1];
    nxt_state = {state[LFSR_W-2:0], fb_cur};
    fb_nxt    = nxt_state[LFSR_W-1] ^ nxt_state[TAP-1];
    fb_seed   = SEED[LFSR_W-1] ^ SEED[TAP-1];
  end

  always_comb begin
    dreg_d = dreg_q;
    act_d  = act_q;
    if (ce) begin
      act_d = st_en;
      if (!st_en)      dreg_d = usr_data;
      else if (!act_q) dreg_d = {fb_seed, SEED};
      else             dreg_d = {fb_nxt, nxt_state};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dreg_q <= '0;
      act_q  <= 1'b0;
    end else begin
      dreg_q <= dreg_d;
      act_q  <= act_d;
    end
  end

  assign char_o    = dreg_q;
  assign act_o     = act_q;
  assign at_seed_o = act_q && (state == SEED);
endmodule

// File: rtl/txst_pattern_gen.sv
module txst_pattern_gen
  import txst_pkg::*;
#(
  parameter int unsigned CHAR_W   = TXST_CHAR_W,
  parameter int unsigned TAP      = TXST_TAP,
  parameter int unsigned SYNC_LEN = TXST_SYNC_LEN,
  parameter logic [CHAR_W-2:0] SEED = 'd1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_st_en,
  input  logic              chr_ce,
  input  logic [CHAR_W-1:0] usr_data,
  output logic [CHAR_W-1:0] tx_char,
  output logic              seq_start
);
  logic rst_sn;
  logic st_en;
  logic st_act;

  txst_rst_sync #(.STAGES(SYNC_LEN)) u_rst_sync (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_sn)
  );

  txst_cfg_latch u_cfg (
    .clk    (clk),
    .rst_n  (rst_sn),
    .wr_en  (cfg_wr),
    .wr_val (cfg_st_en),
    .en_o   (st_en)
  );

  txst_lfsr_core #(.CHAR_W(CHAR_W), .TAP(TAP), .SEED(SEED)) u_core (
    .clk       (clk),
    .rst_n     (rst_sn),
    .ce        (chr_ce),
    .st_en     (st_en),
    .usr_data  (usr_data),
    .char_o    (tx_char),
    .act_o     (st_act),
    .at_seed_o (seq_start)
  );
endmodule

// File: rtl/txst_pattern_gen_chk.sv
module txst_pattern_gen_chk #(
  parameter int unsigned CHAR_W = 10,
  parameter int unsigned TAP    = 5,
  parameter logic [CHAR_W-2:0] SEED = 'd1
) (
  input logic              clk,
  input logic              rst_sn,
  input logic              chr_ce,
  input logic              st_en,
  input logic              st_act,
  input logic [CHAR_W-1:0] usr_data,
  input logic [CHAR_W-1:0] tx_char,
  input logic              seq_start
);
  // R2
  usr_follow_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (chr_ce && !st_en) |=> (tx_char == $past(usr_data)));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    !chr_ce |=> $stable(tx_char));

  // R4
  seed_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (chr_ce && st_en && !st_act) |=> (tx_char[CHAR_W-2:0] == SEED && seq_start));

  // R5
  step_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (chr_ce && st_en && st_act) |=>
      (tx_char[CHAR_W-2:0] == {$past(tx_char[CHAR_W-3:0]),
                               $past(tx_char[CHAR_W-2] ^ tx_char[TAP-1])}));

  // R5
  tenth_bit_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    st_act |-> (tx_char[CHAR_W-1] == (tx_char[CHAR_W-2] ^ tx_char[TAP-1])));

  // R6
  nonzero_state_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    st_act |-> (tx_char[CHAR_W-2:0] != '0));
endmodule

bind txst_pattern_gen txst_pattern_gen_chk #(.CHAR_W(CHAR_W), .TAP(TAP), .SEED(SEED)) u_chk (
  .clk       (clk),
  .rst_sn    (rst_sn),
  .chr_ce    (chr_ce),
  .st_en     (st_en),
  .st_act    (st_act),
  .usr_data  (usr_data),
  .tx_char   (tx_char),
  .seq_start (seq_start)
);

// File: tb/txst_pattern_gen_tb.sv
module txst_pattern_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_wr, cfg_st_en, chr_ce;
  logic [9:0] usr_data;
  logic [9:0] tx_char;
  logic       seq_start;

  int checks = 0;
  int errors = 0;
  logic [8:0] mstate;

  always #2.5 clk = ~clk;

  txst_pattern_gen u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_st_en(cfg_st_en),
    .chr_ce(chr_ce), .usr_data(usr_data), .tx_char(tx_char), .seq_start(seq_start)
  );

  function automatic logic [8:0] m_next(input logic [8:0] s);
    return {s[7:0], s[8] ^ s[4]};
  endfunction

  function automatic logic [9:0] m_char(input logic [8:0] s);
    return {s[8] ^ s[4], s};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input bit wr, input bit val, input bit ce, input logic [9:0] d);
    cfg_wr = wr; cfg_st_en = val; chr_ce = ce; usr_data = d;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; cfg_wr = 0; cfg_st_en = 0; chr_ce = 0; usr_data = '0;
    repeat (3) @(negedge clk);
    chk(tx_char == 10'h000, "R1 char in reset", tx_char, 10'h000);
    chk(seq_start == 1'b0, "R1 seq_start in reset", {9'b0, seq_start}, 10'h000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(tx_char == 10'h000, "R1 char after release", tx_char, 10'h000);
    step(0, 0, 1, 10'h2A5);
    chk(tx_char == 10'h2A5, "R1 latch off after reset", tx_char, 10'h2A5);
  endtask

  task automatic t_user_path;
    step(0, 0, 1, 10'h3C3);
    chk(tx_char == 10'h3C3, "R2 user char", tx_char, 10'h3C3);
    step(0, 0, 1, 10'h001);
    chk(tx_char == 10'h001, "R2 user char seed-like", tx_char, 10'h001);
    chk(seq_start == 1'b0, "R2 no seq_start in user mode", {9'b0, seq_start}, 10'h000);
    step(0, 0, 0, 10'h155);
    chk(tx_char == 10'h001, "R8 hold in user mode", tx_char, 10'h001);
  endtask

  task automatic t_full_period;
    step(1, 1, 0, 10'h0F0);
    chk(tx_char == 10'h001, "R3 write alone no char change", tx_char, 10'h001);
    step(0, 0, 1, 10'h3FF);
    chk(tx_char == 10'h001, "R4 seed char", tx_char, 10'h001);
    chk(seq_start == 1'b1, "R4 seq_start on seed", {9'b0, seq_start}, 10'h001);
    mstate = 9'h001;
    for (int i = 1; i < 511; i++) begin
      mstate = m_next(mstate);
      step(0, 0, 1, 10'(i * 37));
      chk(tx_char == m_char(mstate), "R5 R7 sequence char", tx_char, m_char(mstate));
      chk(seq_start == 1'b0, "R6 no early restart", {9'b0, seq_start}, 10'h000);
    end
    step(0, 0, 1, 10'h2AA);
    chk(tx_char == 10'h001, "R6 seed after 511", tx_char, 10'h001);
    chk(seq_start == 1'b1, "R6 seq_start after 511", {9'b0, seq_start}, 10'h001);
    mstate = 9'h001;
  endtask

  task automatic t_hold_active;
    mstate = m_next(mstate);
    step(0, 0, 1, 10'h000);
    chk(tx_char == m_char(mstate), "R5 advance", tx_char, m_char(mstate));
    step(0, 0, 0, 10'h3FF);
    chk(tx_char == m_char(mstate), "R8 hold in self-test", tx_char, m_char(mstate));
    step(0, 1, 0, 10'h155);
    chk(tx_char == m_char(mstate), "R7 R8 hold ignores data", tx_char, m_char(mstate));
  endtask

  task automatic t_disable_reenable;
    step(1, 0, 0, 10'h000);
    chk(tx_char == m_char(mstate), "R9 write 0 no change yet", tx_char, m_char(mstate));
    step(0, 0, 1, 10'h1B4);
    chk(tx_char == 10'h1B4, "R9 user after disable", tx_char, 10'h1B4);
    step(1, 1, 0, 10'h000);
    step(0, 0, 1, 10'h3FF);
    chk(tx_char == 10'h001, "R9 restart from seed", tx_char, 10'h001);
    chk(seq_start == 1'b1, "R9 seq_start on restart", {9'b0, seq_start}, 10'h001);
    step(0, 0, 1, 10'h3FF);
    chk(tx_char == m_char(9'h002), "R5 second char", tx_char, m_char(9'h002));
  endtask

  task automatic t_reset_active;
    step(0, 0, 1, 10'h000);
    #1 rst_n = 1'b0;
    #1;
    chk(tx_char == 10'h000, "R10 async clear", tx_char, 10'h000);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    step(0, 0, 1, 10'h0E7);
    chk(tx_char == 10'h0E7, "R10 latch cleared", tx_char, 10'h0E7);
  endtask

  initial begin
    t_reset();
    t_user_path();
    t_full_period();
    t_hold_active();
    t_disable_reenable();
    t_reset_active();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule